// File: doc/BRIEF.md
# Slot-Swizzled Interrupt Router

This block gathers level-sensitive interrupt requests from up to 64 bus functions. Each function raises or drops one of four request pins (A to D, numbered 0 to 3). The router rotates the pin by the function's slot number so that neighbouring slots spread across four shared request lines. It keeps one level bit for each function on each shared line, and drives each line high while any of its bits is set.

Four 8-bit steering registers sit in configuration space. Each one connects a shared line to one of 16 inputs of a legacy interrupt controller, or leaves the line unconnected. The controller request vector is the OR of every connected line steered to each input.

A request is presented as a one-cycle strobe that carries the function index, the bus address byte (slot in bits 7:3, function number in bits 2:0), the pin and the new level. Steering registers are written through a byte-wide configuration write port.

Top module: `irq_router`

## Requirements
- R1: The shared line for a request is (pin + slot) mod 4, where slot is `req_devfn_i[7:3]` and pin 0..3 stands for A..D.
- R2: One level bit is held per function index (0..63) per shared line. A request sets only the bit of its own function on its computed line to `req_level_i`, and leaves all other bits unchanged.
- R3: The steering register of line k (k = 0..3) is written at configuration address 0x60 + k. A write to any other address changes nothing.
- R4: A steering value below 16 drives the line onto `irq_o[value]`. A value of 16 or more leaves the line unconnected.
- R5: A connected line is high while at least one function's level bit for that line is set, and low once all of its bits are clear.
- R6: When two or more lines are steered to the same input, that output bit is the OR of those lines.
- R7: After reset all steering registers hold 0x80, all level bits are zero and `irq_o` is zero.
- R8: A request strobe or configuration write sampled at a rising clock edge shows on `irq_o` right after that edge. Without a strobe or write, `irq_o` holds its value.
- R9: A request strobe and a configuration write in the same cycle both take effect at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Interrupt request strobe, one cycle per level change |
| req_func_i | input | 6 | Function index that owns the level bit |
| req_devfn_i | input | 8 | Slot (bits 7:3) and function number (bits 2:0) |
| req_pin_i | input | 2 | Request pin 0..3 (A..D) |
| req_level_i | input | 1 | New level of the pin |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 8 | Configuration byte address |
| cfg_wdata_i | input | 8 | Configuration write data |
| irq_o | output | 16 | Request levels towards the interrupt controller |

## Verification
Directed cases walk one pin across consecutive slots, so a wrong rotation or a bit taken from the wrong part of the address moves the output to another controller input. Other directed cases cover two functions sharing a line where one then clears, two lines steered onto one input, and steering values 15, 16 and 0x80. Writes to 0x5F and 0x64 check that address decoding does not alias. A seeded random mix of requests, steering writes, combined cycles and idle cycles is then compared against a bench model after every cycle. That run catches lost or cross-written level bits and stale outputs.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int unsigned DEVFN_W    = 8;
  localparam int unsigned SLOT_LSB   = 3;
  localparam int unsigned PIN_W      = 2;
  localparam int unsigned CFG_ADDR_W = 8;
  localparam int unsigned ROUTE_W    = 8;
  localparam logic [ROUTE_W-1:0] ROUTE_RESET = 8'h80;
  localparam logic [CFG_ADDR_W-1:0] ROUTE_BASE = 8'h60;

  typedef logic [DEVFN_W-1:0] devfn_t;
  typedef logic [ROUTE_W-1:0] route_t;
endpackage

// File: rtl/irq_swizzle.sv
module irq_swizzle
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_LINES = 4,
  localparam int unsigned LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  devfn_t            devfn_i,
  input  logic [PIN_W-1:0]  pin_i,
  output logic [LINE_W-1:0] line_o
);
  localparam int unsigned SLOT_W = DEVFN_W - SLOT_LSB;
  logic [SLOT_W-1:0] slot;
  logic [SLOT_W:0]   sum;

  assign slot = devfn_i[DEVFN_W-1:SLOT_LSB];
  assign sum  = {1'b0, slot} + {{(SLOT_W+1-PIN_W){1'b0}}, pin_i};
  // mod NUM_LINES; NUM_LINES is a power of two
  assign line_o = sum[LINE_W-1:0];
endmodule

// File: rtl/irq_level_store.sv
module irq_level_store #(
  parameter int unsigned NUM_FUNCS = 64,
  parameter int unsigned NUM_LINES = 4,
  localparam int unsigned FUNC_W = (NUM_FUNCS > 1) ? $clog2(NUM_FUNCS) : 1,
  localparam int unsigned LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [FUNC_W-1:0]    func_i,
  input  logic [LINE_W-1:0]    line_i,
  input  logic                 level_i,
  output logic [NUM_LINES-1:0] line_any_o
);
  logic func_ok;
  assign func_ok = 32'(func_i) < NUM_FUNCS;

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    logic [NUM_FUNCS-1:0] bits_q;
    logic hit;
    assign hit = we_i && func_ok && (32'(line_i) == l);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        bits_q <= '0;
      end else if (hit) begin
        bits_q[func_i] <= level_i;
      end
    end

    assign line_any_o[l] = |bits_q;
  end
endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_LINES = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [CFG_ADDR_W-1:0]         addr_i,
  input  route_t                        wdata_i,
  output logic [NUM_LINES*ROUTE_W-1:0]  route_o
);
  for (genvar l = 0; l < NUM_LINES; l++) begin : g_reg
    localparam logic [CFG_ADDR_W-1:0] MY_ADDR = ROUTE_BASE + CFG_ADDR_W'(l);
    route_t q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q <= ROUTE_RESET;
      end else if (we_i && (addr_i == MY_ADDR)) begin
        q <= wdata_i;
      end
    end

    assign route_o[l*ROUTE_W +: ROUTE_W] = q;
  end
endmodule

// File: rtl/irq_steer.sv
module irq_steer
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_LINES = 4,
  parameter int unsigned NUM_OUTS  = 16
) (
  input  logic [NUM_LINES-1:0]         line_any_i,
  input  logic [NUM_LINES*ROUTE_W-1:0] route_i,
  output logic [NUM_OUTS-1:0]          irq_o
);
  for (genvar o = 0; o < NUM_OUTS; o++) begin : g_out
    logic [NUM_LINES-1:0] sel;
    for (genvar l = 0; l < NUM_LINES; l++) begin : g_src
      // values >= NUM_OUTS never match an output index: line disconnected
      assign sel[l] = line_any_i[l] && (route_i[l*ROUTE_W +: ROUTE_W] == ROUTE_W'(o));
    end
    assign irq_o[o] = |sel;
  end
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_FUNCS = 64,
  parameter int unsigned NUM_LINES = 4,
  parameter int unsigned NUM_OUTS  = 16,
  localparam int unsigned FUNC_W = (NUM_FUNCS > 1) ? $clog2(NUM_FUNCS) : 1,
  localparam int unsigned LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_valid_i,
  input  logic [FUNC_W-1:0]     req_func_i,
  input  logic [DEVFN_W-1:0]    req_devfn_i,
  input  logic [PIN_W-1:0]      req_pin_i,
  input  logic                  req_level_i,
  input  logic                  cfg_we_i,
  input  logic [CFG_ADDR_W-1:0] cfg_addr_i,
  input  logic [ROUTE_W-1:0]    cfg_wdata_i,
  output logic [NUM_OUTS-1:0]   irq_o
);
  logic [LINE_W-1:0]            req_line;
  logic [NUM_LINES-1:0]         line_any;
  logic [NUM_LINES*ROUTE_W-1:0] route_flat;

  irq_swizzle #(.NUM_LINES(NUM_LINES)) u_swizzle (
    .devfn_i (req_devfn_i),
    .pin_i   (req_pin_i),
    .line_o  (req_line)
  );

  irq_level_store #(.NUM_FUNCS(NUM_FUNCS), .NUM_LINES(NUM_LINES)) u_levels (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (req_valid_i),
    .func_i     (req_func_i),
    .line_i     (req_line),
    .level_i    (req_level_i),
    .line_any_o (line_any)
  );

  irq_route_regs #(.NUM_LINES(NUM_LINES)) u_routes (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .route_o (route_flat)
  );

  irq_steer #(.NUM_LINES(NUM_LINES), .NUM_OUTS(NUM_OUTS)) u_steer (
    .line_any_i (line_any),
    .route_i    (route_flat),
    .irq_o      (irq_o)
  );
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_LINES = 4,
  parameter int unsigned NUM_OUTS  = 16
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         req_valid_i,
  input logic [DEVFN_W-1:0]           req_devfn_i,
  input logic [PIN_W-1:0]             req_pin_i,
  input logic                         req_level_i,
  input logic                         cfg_we_i,
  input logic [CFG_ADDR_W-1:0]        cfg_addr_i,
  input logic [NUM_LINES*ROUTE_W-1:0] route_flat,
  input logic [NUM_OUTS-1:0]          irq_o
);
  logic [1:0]   chk_line;
  route_t       chk_route;
  logic         chk_all_off;
  logic         cfg_hits;

  assign chk_line  = 2'(req_pin_i + req_devfn_i[4:3]);
  assign chk_route = route_flat[32'(chk_line)*ROUTE_W +: ROUTE_W];
  assign cfg_hits  = cfg_we_i && (cfg_addr_i >= ROUTE_BASE) &&
                     (cfg_addr_i < ROUTE_BASE + CFG_ADDR_W'(NUM_LINES));

  always_comb begin
    chk_all_off = 1'b1;
    for (int l = 0; l < NUM_LINES; l++)
      if (route_flat[l*ROUTE_W +: ROUTE_W] < ROUTE_W'(NUM_OUTS)) chk_all_off = 1'b0;
  end

  AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_valid_i && !cfg_we_i) |=> $stable(irq_o)); // R8

  AST_FOREIGN_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_valid_i && cfg_we_i && !cfg_hits) |=> $stable(irq_o)); // R3

  AST_SET_REACHES_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_level_i && !cfg_we_i && chk_route < ROUTE_W'(NUM_OUTS))
      |=> irq_o[$past(chk_route[3:0])]); // R1

  AST_ALL_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_all_off |-> (irq_o == '0)); // R4

  AST_LINE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(irq_o) <= NUM_LINES); // R6
endmodule

bind irq_router irq_router_chk #(.NUM_LINES(NUM_LINES), .NUM_OUTS(NUM_OUTS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_devfn_i (req_devfn_i),
  .req_pin_i   (req_pin_i),
  .req_level_i (req_level_i),
  .cfg_we_i    (cfg_we_i),
  .cfg_addr_i  (cfg_addr_i),
  .route_flat  (route_flat),
  .irq_o       (irq_o)
);

// File: tb/irq_router_test.sv
module irq_router_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [5:0]  req_func_i = '0;
  logic [7:0]  req_devfn_i = '0;
  logic [1:0]  req_pin_i = '0;
  logic        req_level_i = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [7:0]  cfg_addr_i = '0;
  logic [7:0]  cfg_wdata_i = '0;
  logic [15:0] irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [63:0] lvl_m [4];
  logic [7:0]  rt_m  [4];

  always #4 clk_i = ~clk_i;

  irq_router uut (.*);

  function automatic logic [15:0] exp_irq();
    logic [15:0] v = '0;
    for (int l = 0; l < 4; l++)
      if (rt_m[l] < 8'd16 && |lvl_m[l]) v[rt_m[l][3:0]] = 1'b1;
    return v;
  endfunction

  function automatic int line_of(logic [7:0] devfn, logic [1:0] pin);
    return (int'(pin) + int'(devfn[7:3])) % 4;
  endfunction

  task automatic check(input string tag);
    logic [15:0] e = exp_irq();
    checks++;
    if (irq_o !== e) begin
      errors++;
      $display("FAIL %s: irq_o=%h expected=%h", tag, irq_o, e);
    end
  endtask

  // drive one cycle; any of req/cfg may be active
  task automatic step(input bit rv, input logic [5:0] f, input logic [7:0] d,
                      input logic [1:0] p, input bit lv,
                      input bit cw, input logic [7:0] a, input logic [7:0] w);
    @(negedge clk_i);
    req_valid_i = rv; req_func_i = f; req_devfn_i = d; req_pin_i = p; req_level_i = lv;
    cfg_we_i = cw; cfg_addr_i = a; cfg_wdata_i = w;
    @(negedge clk_i);
    req_valid_i = 1'b0; cfg_we_i = 1'b0;
    if (rv) lvl_m[line_of(d, p)][f] = lv;
    if (cw && a >= 8'h60 && a <= 8'h63) rt_m[a - 8'h60] = w;
  endtask

  task automatic req(input logic [5:0] f, input logic [7:0] d, input logic [1:0] p, input bit lv);
    step(1'b1, f, d, p, lv, 1'b0, 8'h00, 8'h00);
  endtask

  task automatic cfg(input logic [7:0] a, input logic [7:0] w);
    step(1'b0, 6'd0, 8'd0, 2'd0, 1'b0, 1'b1, a, w);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: irq_o=%h expected=finished", irq_o);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240621));
    for (int l = 0; l < 4; l++) begin lvl_m[l] = '0; rt_m[l] = 8'h80; end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R7 reset idle");
    // R7: lines disabled after reset even with a level raised
    req(6'd0, 8'h00, 2'd0, 1'b1);
    check("R7 routes disabled at reset");
    // steer lines 0..3 to inputs 3,5,7,9
    cfg(8'h60, 8'd3); cfg(8'h61, 8'd5); cfg(8'h62, 8'd7); cfg(8'h63, 8'd9);
    check("R3 R8 line0 now visible");
    req(6'd0, 8'h00, 2'd0, 1'b0);
    check("R5 line cleared");
    // R1: pin A across slots 0..7, function number bits must not matter
    for (int s = 0; s < 8; s++) begin
      req(6'(s), 8'((s << 3) | 5), 2'd0, 1'b1);
      check("R1 swizzle set");
      req(6'(s), 8'((s << 3) | 5), 2'd0, 1'b0);
      check("R1 swizzle clear");
    end
    // R1: pin D in slot 2 -> line 1
    req(6'd9, 8'h10, 2'd3, 1'b1);
    check("R1 pin D slot 2");
    req(6'd9, 8'h10, 2'd3, 1'b0);
    // R5 R2: two functions on one line, index 63 included
    req(6'd63, 8'h08, 2'd1, 1'b1);
    req(6'd4,  8'h00, 2'd2, 1'b1);
    req(6'd63, 8'h08, 2'd1, 1'b0);
    check("R5 other function keeps line high");
    req(6'd4, 8'h00, 2'd2, 1'b0);
    check("R5 last bit cleared");
    // R2: same function on two lines is two separate bits
    req(6'd7, 8'h00, 2'd0, 1'b1);
    req(6'd7, 8'h00, 2'd1, 1'b1);
    req(6'd7, 8'h00, 2'd0, 1'b0);
    check("R2 per-line bits independent");
    // R6: lines 0 and 1 onto input 5
    cfg(8'h60, 8'd5);
    req(6'd7, 8'h00, 2'd0, 1'b1);
    req(6'd7, 8'h00, 2'd1, 1'b0);
    check("R6 shared input, line0 only");
    req(6'd7, 8'h00, 2'd0, 1'b0);
    check("R6 shared input low");
    // R4: value 15 connects, 16 disconnects
    req(6'd1, 8'h00, 2'd2, 1'b1);
    cfg(8'h62, 8'd15);
    check("R4 value 15");
    cfg(8'h62, 8'd16);
    check("R4 value 16 disables");
    // R3: neighbouring addresses ignored
    cfg(8'h62, 8'd11);
    cfg(8'h5F, 8'd2);
    check("R3 addr 0x5F ignored");
    cfg(8'h64, 8'd2);
    check("R3 addr 0x64 ignored");
    // R9: request and write together
    step(1'b1, 6'd20, 8'h18, 2'd0, 1'b1, 1'b1, 8'h63, 8'd0);
    check("R9 combined cycle");
    // R8: idle cycles hold value
    repeat (3) @(negedge clk_i);
    check("R8 hold when idle");
    // random mix
    for (int i = 0; i < 600; i++) begin
      int op = $urandom % 4;
      logic [7:0] a = 8'h5E + 8'($urandom % 8);
      logic [7:0] w = ($urandom % 4 == 0) ? 8'h80 : 8'($urandom % 20);
      if (op == 3) begin
        @(negedge clk_i);
        check("R8 random idle");
      end else begin
        step(op != 1, 6'($urandom), 8'($urandom), 2'($urandom), 1'($urandom),
             op != 0, a, w);
        check("R2 R5 random");
      end
    end
    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule